// File: doc/BRIEF.md
# Programmable Down-Counting Timer with Watchdog Mode

This block is a 16-bit down-counter driven by an 8-bit programmable clock divider, set up by software through a byte-wide register port. While counting is enabled, the divider produces one tick every (code+1) qualified clocks. Each tick decrements the counter. A tick that finds the counter at zero reloads it from the software load value and raises an end-of-count strobe for one clock. The counter can run continuously or stop after one terminal count. An external input, passed through a synchronizer with rising-edge detection, decides how counting is qualified. It can act as an event clock, as a level gate, as a one-shot trigger, or as a retrigger that restarts the count on every edge.

Setting a sticky enable turns the same counter into a watchdog. The counter then runs from the system clock, whatever the run bit and input mode say. Software keeps it alive by writing the counter low byte again. If the count expires, a reset request output goes high for a fixed number of clocks. Only a block reset clears watchdog mode.

Register map (address on `reg_addr`): 0 = counter high byte, 1 = counter low byte, 2 = divider code, 3 = control, 4 = watchdog enable (bit 0). Control bits: 7 = run, 6 = single-shot, 5:4 = input mode, 3:0 = stored with no function.

Top module: `ptw_timer`

## Requirements
- R1: After reset, addresses 0, 1 and 2 read FFh, address 3 reads 12h and address 4 reads 00h, with `eoc_pulse` and `wdog_rst` low.
- R2: The divider code P (address 2) divides by P+1, so in continuous gated mode with the input held high and load value L, `eoc_pulse` repeats every (L+1)*(P+1) clocks.
- R3: `eoc_pulse` is high for exactly one clock, one cycle after a tick finds the counter at zero, and the counter reloads from the load value so counting carries on.
- R4: In gated mode (control bits 5:4 = 01) with the synchronized input low, the counter holds its value and no `eoc_pulse` occurs.
- R5: In event mode (control bits 5:4 = 00) with divider code 0, each synchronized rising edge of `ext_in` decrements the counter, and the (L+1)-th edge produces one `eoc_pulse` and reloads L.
- R6: With control bit 6 set, the terminal count produces one `eoc_pulse` and clears control bit 7, and no further pulses follow.
- R7: In triggerable mode (bits 5:4 = 10) no counting happens before a rising edge. An edge starts one count that ends with `eoc_pulse` 7 clocks after the input rises (L=3, P=0), and edges during that count are ignored.
- R8: In retriggerable mode (bits 5:4 = 11) each rising edge reloads the counter and restarts the divider. A second edge two clocks after the first delays `eoc_pulse` to 9 clocks after the first input rise (L=3, P=0).
- R9: Addresses 0 and 1 read the live counter bytes while it runs. A write to address 0 replaces the counter high byte on the fly. A write to address 1 loads the full counter from the load value and restarts the divider.
- R10: In watchdog mode, writing address 1 refreshes the count. Without a refresh, `wdog_rst` rises 6 clocks after a refresh that loaded 5 (P=0) and stays high for RST_LEN (default 4) clocks.
- R11: Once bit 0 of address 4 has been written as 1, it reads 1 until reset. Clearing control bit 7 or writing 0 to address 4 stops neither the count nor `wdog_rst`.
- R12: With control bit 7 clear and watchdog mode off, the counter holds its value and no `eoc_pulse` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| ext_in | input | 1 | Asynchronous external count input |
| eoc_pulse | output | 1 | One-clock end-of-count strobe |
| wdog_rst | output | 1 | Watchdog reset request |

## Verification
Register writes take effect at the clock edge inside the write strobe. Reads are combinational, so each is sampled 1 ns after `reg_addr` is driven on a falling edge. An `ext_in` change reaches the counting logic through two synchronizer flops and acts on the third edge after it is driven. `eoc_pulse` and `wdog_rst` are registered and rise one edge after the terminal cycle. From these facts the bench derives exact cycle counts for the trigger (7), retrigger (9) and watchdog (6) cases. It counts edges from the stimulus and samples each output 1 ns after the counted edge. Divider ratios are checked as the spacing between successive strobes, so the checks do not depend on when counting starts.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CNT_HI = 3'd0,
        RA_CNT_LO = 3'd1,
        RA_DIV    = 3'd2,
        RA_CTRL   = 3'd3,
        RA_WDOG   = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        IM_EVENT  = 2'b00,
        IM_GATED  = 2'b01,
        IM_TRIG   = 2'b10,
        IM_RETRIG = 2'b11
    } in_mode_e;

    typedef struct packed {
        logic     run;
        logic     single;
        in_mode_e mode;
        logic [3:0] spare;
    } ctrl_t;

    localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h12;

    // Whether the divider may advance this cycle, by input mode.
    function automatic logic count_qualify(in_mode_e mode, logic level,
                                           logic rise, logic armed);
        logic q;
        unique case (mode)
            IM_EVENT:  q = rise;
            IM_GATED:  q = level;
            IM_TRIG:   q = armed;
            IM_RETRIG: q = armed;
            default:   q = 1'b0;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/ptw_sync.sv
module ptw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] shift_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], din};
            prev_q  <= shift_q[STAGES-1];
        end
    end

    assign level = shift_q[STAGES-1];
    assign rise  = shift_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ptw_prescaler.sv
module ptw_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         advance,
    input  logic [W-1:0] div_code,
    output logic         tick
);
    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end = (cnt_q == '0);
    assign tick   = advance & ~restart & at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
        end else if (restart) begin
            cnt_q <= div_code;
        end else if (advance) begin
            cnt_q <= at_end ? div_code : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/ptw_counter.sv
module ptw_counter #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_hi,
    input  logic            wr_lo,
    input  logic [BW-1:0]   wdata,
    input  logic            reload,
    input  logic            tick,
    output logic [2*BW-1:0] value,
    output logic            tc
);
    localparam int W = 2 * BW;

    logic [W-1:0] load_q;
    logic [W-1:0] cnt_q;
    logic         at_zero;

    assign at_zero = (cnt_q == '0);
    assign tc      = tick & at_zero & ~reload & ~wr_hi & ~wr_lo;
    assign value   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '1;
            cnt_q  <= '1;
        end else begin
            if (wr_hi) load_q[W-1:BW] <= wdata;
            if (wr_lo) load_q[BW-1:0] <= wdata;

            if (wr_lo) begin
                cnt_q <= {load_q[W-1:BW], wdata};
            end else if (wr_hi) begin
                cnt_q[W-1:BW] <= wdata;
            end else if (reload) begin
                cnt_q <= load_q;
            end else if (tick) begin
                cnt_q <= at_zero ? load_q : cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ptw_stretch.sv
module ptw_stretch #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= CW'(LEN);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/ptw_timer.sv
module ptw_timer
    import ptw_pkg::*;
#(
    parameter int RST_LEN     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              ext_in,
    output logic              eoc_pulse,
    output logic              wdog_rst
);
    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] div_q;
    logic              wdog_en_q;
    logic              armed_q;
    logic              eoc_q;

    logic wr_hi, wr_lo, wr_div, wr_ctrl, wr_wdog;
    logic in_level, in_rise;
    logic trig_start, retrig_load, advance, tick, tc;
    logic [CNT_W-1:0] cnt_w;

    // Flat views for the bound checker.
    logic       run_w, single_w;
    logic [1:0] mode_w;

    assign wr_hi   = reg_wr && (reg_addr == RA_CNT_HI);
    assign wr_lo   = reg_wr && (reg_addr == RA_CNT_LO);
    assign wr_div  = reg_wr && (reg_addr == RA_DIV);
    assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    assign wr_wdog = reg_wr && (reg_addr == RA_WDOG);

    ptw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (ext_in),
        .level (in_level),
        .rise  (in_rise)
    );

    // Edge-driven starts only apply to timer mode while running.
    always_comb begin
        trig_start  = 1'b0;
        retrig_load = 1'b0;
        if (ctrl_q.run && !wdog_en_q && in_rise) begin
            if (ctrl_q.mode == IM_TRIG && !armed_q) trig_start = 1'b1;
            if (ctrl_q.mode == IM_RETRIG) begin
                trig_start  = 1'b1;
                retrig_load = 1'b1;
            end
        end
    end

    always_comb begin
        if (wdog_en_q) begin
            advance = 1'b1;
        end else begin
            advance = ctrl_q.run &
                      count_qualify(ctrl_q.mode, in_level, in_rise, armed_q);
        end
    end

    ptw_prescaler #(.W(BYTE_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .restart  (wr_lo | trig_start),
        .advance  (advance),
        .div_code (div_q),
        .tick     (tick)
    );

    ptw_counter #(.BW(BYTE_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .wr_hi  (wr_hi),
        .wr_lo  (wr_lo),
        .wdata  (reg_wdata),
        .reload (retrig_load),
        .tick   (tick),
        .value  (cnt_w),
        .tc     (tc)
    );

    ptw_stretch #(.LEN(RST_LEN)) u_rst (
        .clk   (clk),
        .rst   (rst),
        .fire  (tc & wdog_en_q),
        .pulse (wdog_rst)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= ctrl_t'(CTRL_RESET);
            div_q     <= '1;
            wdog_en_q <= 1'b0;
            armed_q   <= 1'b0;
            eoc_q     <= 1'b0;
        end else begin
            eoc_q <= tc;

            if (wr_div) div_q <= reg_wdata;

            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(reg_wdata);
            end else if (tc && ctrl_q.single && !wdog_en_q) begin
                ctrl_q.run <= 1'b0;
            end

            if (wr_wdog && reg_wdata[0]) wdog_en_q <= 1'b1;

            if (!ctrl_q.run || wdog_en_q) begin
                armed_q <= 1'b0;
            end else if (trig_start) begin
                armed_q <= 1'b1;
            end else if (tc) begin
                armed_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_CNT_HI: reg_rdata = cnt_w[CNT_W-1:BYTE_W];
            RA_CNT_LO: reg_rdata = cnt_w[BYTE_W-1:0];
            RA_DIV:    reg_rdata = div_q;
            RA_CTRL:   reg_rdata = ctrl_q;
            RA_WDOG:   reg_rdata = {{(BYTE_W-1){1'b0}}, wdog_en_q};
            default:   reg_rdata = '0;
        endcase
    end

    assign eoc_pulse = eoc_q;
    assign run_w     = ctrl_q.run;
    assign single_w  = ctrl_q.single;
    assign mode_w    = ctrl_q.mode;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic        eoc,
    input logic        wdog_rst,
    input logic        wdog_en,
    input logic        run,
    input logic        single,
    input logic [1:0]  mode,
    input logic        level,
    input logic [15:0] cnt
);
    AST_EOC_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        eoc |-> ($past(cnt) == 16'd0)); // R3

    AST_GATE_LOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!wdog_en && run && mode == 2'b01 && !level && !reg_wr) |=> $stable(cnt)); // R4

    AST_SINGLE_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
        (eoc && $past(single && !wdog_en && !(reg_wr && reg_addr == 3'd3))) |-> !run); // R6

    AST_RST_NEEDS_WDOG: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |-> wdog_en); // R10

    AST_RST_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(wdog_rst) |-> ($past(cnt) == 16'd0)); // R10

    AST_WDOG_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(wdog_en) |-> wdog_en); // R11

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!wdog_en && !run && !reg_wr) |=> $stable(cnt)); // R12
endmodule

bind ptw_timer ptw_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .eoc      (eoc_pulse),
    .wdog_rst (wdog_rst),
    .wdog_en  (wdog_en_q),
    .run      (run_w),
    .single   (single_w),
    .mode     (mode_w),
    .level    (in_level),
    .cnt      (cnt_w)
);

// File: tb/ptw_timer_tb.sv
module ptw_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ext_in = 1'b0;
    logic       eoc_pulse;
    logic       wdog_rst;

    int checks = 0;
    int errors = 0;
    int eoc_total = 0;
    int rst_total = 0;

    always #4 clk = ~clk;

    ptw_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ext_in    (ext_in),
        .eoc_pulse (eoc_pulse),
        .wdog_rst  (wdog_rst)
    );

    always @(negedge clk) begin
        if (eoc_pulse) eoc_total++;
        if (wdog_rst)  rst_total++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic setup(input logic [7:0] ctrl_stop, input logic [7:0] p,
                         input logic [7:0] hi, input logic [7:0] lo);
        wr(3'd3, ctrl_stop);
        wr(3'd2, p);
        wr(3'd0, hi);
        wr(3'd1, lo);
    endtask

    task automatic set_in(input logic v);
        @(negedge clk);
        ext_in = v;
        repeat (4) @(negedge clk);
    endtask

    // Period between two successive strobes; also checks strobe width.
    task automatic measure(input string req, input int exp_p);
        int n = 0;
        int p = 0;
        do begin @(posedge clk); #1; n++; end while (!eoc_pulse && n < 3000);
        do begin
            @(posedge clk); #1; p++;
            if (p == 1) chk("R3 strobe one clock wide", int'(eoc_pulse), 0);
        end while (!eoc_pulse && p < 3000);
        chk(req, p, exp_p);
    endtask

    task automatic test_reset();
        logic [7:0] d;
        rd(3'd0, d); chk("R1 cnt hi reset", d, 8'hFF);
        rd(3'd1, d); chk("R1 cnt lo reset", d, 8'hFF);
        rd(3'd2, d); chk("R1 divider reset", d, 8'hFF);
        rd(3'd3, d); chk("R1 ctrl reset", d, 8'h12);
        rd(3'd4, d); chk("R1 wdog reset", d, 8'h00);
        chk("R1 eoc low", int'(eoc_pulse), 0);
        chk("R1 wdog_rst low", int'(wdog_rst), 0);
    endtask

    task automatic test_gated_ratio();
        set_in(1'b1);
        setup(8'h10, 8'd0, 8'd0, 8'd3); wr(3'd3, 8'h90);
        measure("R2 period P=0 L=3", 4);
        setup(8'h10, 8'd2, 8'd0, 8'd1); wr(3'd3, 8'h90);
        measure("R2 period P=2 L=1", 6);
        setup(8'h10, 8'd1, 8'd0, 8'd3); wr(3'd3, 8'h90);
        measure("R2 R3 period P=1 L=3", 8);
    endtask

    task automatic test_gate_low();
        logic [7:0] a, b;
        int base;
        set_in(1'b0);
        base = eoc_total;
        rd(3'd1, a);
        repeat (20) @(negedge clk);
        rd(3'd1, b);
        chk("R4 gated low holds count", b, a);
        chk("R4 gated low no strobe", eoc_total - base, 0);
    endtask

    task automatic pulse_in();
        @(negedge clk); ext_in = 1'b1;
        repeat (3) @(negedge clk); ext_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic test_event();
        logic [7:0] d;
        int base;
        set_in(1'b0);
        setup(8'h00, 8'd0, 8'd0, 8'd2); wr(3'd3, 8'h80);
        base = eoc_total;
        pulse_in(); pulse_in();
        rd(3'd1, d); chk("R5 two edges count down to 0", d, 8'd0);
        chk("R5 no strobe after two edges", eoc_total - base, 0);
        pulse_in();
        chk("R5 strobe on third edge", eoc_total - base, 1);
        rd(3'd1, d); chk("R5 reload after terminal", d, 8'd2);
    endtask

    task automatic test_single();
        logic [7:0] d;
        int base;
        set_in(1'b1);
        setup(8'h10, 8'd0, 8'd0, 8'd3);
        base = eoc_total;
        wr(3'd3, 8'hD0);
        repeat (30) @(negedge clk);
        chk("R6 single gives one strobe", eoc_total - base, 1);
        rd(3'd3, d); chk("R6 run bit cleared", d, 8'h50);
    endtask

    // Rise on ext_in; optional second rise; returns edges until strobe.
    task automatic trig_run(input bit two, output int got, output int count);
        int base = eoc_total;
        got = 0;
        @(negedge clk); ext_in = 1'b1;
        for (int n = 1; n <= 30; n++) begin
            @(posedge clk); #1;
            if (eoc_pulse && got == 0) got = n;
            @(negedge clk);
            if (two && n == 1) ext_in = 1'b0;
            if (two && n == 2) ext_in = 1'b1;
        end
        ext_in = 1'b0;
        repeat (4) @(negedge clk);
        count = eoc_total - base;
    endtask

    task automatic test_trig();
        int got, cnt, base;
        set_in(1'b0);
        setup(8'h20, 8'd0, 8'd0, 8'd3); wr(3'd3, 8'hA0);
        base = eoc_total;
        repeat (20) @(negedge clk);
        chk("R7 no count before trigger", eoc_total - base, 0);
        trig_run(1'b1, got, cnt);
        chk("R7 strobe delay ignores second edge", got, 7);
        chk("R7 one count per trigger", cnt, 1);
    endtask

    task automatic test_retrig();
        int got, cnt;
        set_in(1'b0);
        setup(8'h30, 8'd0, 8'd0, 8'd3); wr(3'd3, 8'hB0);
        trig_run(1'b0, got, cnt);
        chk("R8 single edge delay", got, 7);
        trig_run(1'b1, got, cnt);
        chk("R8 second edge restarts count", got, 9);
        chk("R8 one strobe after restart", cnt, 1);
    endtask

    task automatic test_stop();
        logic [7:0] a, b;
        int base;
        set_in(1'b1);
        setup(8'h10, 8'd0, 8'd1, 8'd0); wr(3'd3, 8'h90);
        repeat (5) @(negedge clk);
        wr(3'd3, 8'h10);
        base = eoc_total;
        rd(3'd1, a);
        repeat (20) @(negedge clk);
        rd(3'd1, b);
        chk("R12 stopped counter holds", b, a);
        chk("R12 stopped no strobe", eoc_total - base, 0);
    endtask

    task automatic test_live_access();
        logic [7:0] d;
        set_in(1'b1);
        setup(8'h10, 8'hFF, 8'h12, 8'h34); wr(3'd3, 8'h90);
        rd(3'd0, d); chk("R9 live hi read", d, 8'h12);
        rd(3'd1, d); chk("R9 live lo read", d, 8'h34);
        wr(3'd0, 8'h05);
        rd(3'd0, d); chk("R9 hi written on the fly", d, 8'h05);
        repeat (600) @(negedge clk);
        rd(3'd1, d); chk("R9 lo after two divided ticks", d, 8'h32);
        rd(3'd0, d); chk("R9 hi kept after ticks", d, 8'h05);
        wr(3'd3, 8'h10);
    endtask

    task automatic test_watchdog();
        logic [7:0] d;
        int base, n, w;
        setup(8'h10, 8'd0, 8'd0, 8'd5);
        wr(3'd4, 8'h01);
        base = rst_total;
        for (int i = 0; i < 8; i++) begin
            wr(3'd1, 8'd5);
            repeat (2) @(negedge clk);
        end
        chk("R10 refresh keeps reset low", rst_total - base, 0);
        wr(3'd1, 8'd5);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!wdog_rst && n < 50);
        chk("R10 expiry delay", n, 6);
        w = 1;
        do begin @(posedge clk); #1; if (wdog_rst) w++; end while (wdog_rst && w < 50);
        chk("R10 reset width", w, 4);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h00);
        rd(3'd4, d); chk("R11 enable sticky", d, 8'h01);
        base = rst_total;
        repeat (20) @(negedge clk);
        chk("R11 cannot stop watchdog", int'(rst_total - base > 0), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL TIMEOUT run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_gated_ratio();
        test_gate_low();
        test_event();
        test_single();
        test_trig();
        test_retrig();
        test_stop();
        test_live_access();
        test_watchdog();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule